// File: doc/BRIEF.md
# ECC Write-Path Fault Injector

This block sits on a memory controller's write-data path, just after the SECDED check-bit generator. Test software loads one or more 32-bit fault masks through a small register write port. On the next accepted write beat, every set mask bit inverts the matching data bit. The check bits are still computed from the original data, so reading that location back later shows a correctable error (one flipped bit) or a detectable one (two flipped bits). Once the masks have been applied to one beat, they clear themselves.

The data path is 64 or 128 bits wide. Each 64-bit lane carries its own 8 check bits. Each beat leaves the block one clock after it is accepted, as a single word with the data in the low bits and the check bits above it. When the parameters disable ECC or the test feature, the mask registers do not exist, register writes are ignored, and data passes through unmodified.

Top module: `ecc_fault_inject`

## Requirements
- R1: After reset, every mask is zero, `out_valid` is low and `out_word` is all zeros.
- R2: A beat is accepted on a rising edge where `wr_valid` and `wr_ready` are both high. `out_valid` is high in the cycle after an accepted beat, and `out_word` then carries that beat. One register stage gives a latency of exactly one cycle.
- R3: A write to `cfg_wr_addr` = k loads mask word k. On the next accepted beat, a 1 in mask word k inverts data bits [32k+31:32k]. The output data field is `out_word[DATA_W-1:0]`.
- R4: The check bits are computed from the uncorrupted input data, one byte per 64-bit lane. The byte for lane l sits at `out_word[DATA_W+8l+7 : DATA_W+8l]`. The 64 data bits of a lane are placed, in ascending order, at codeword positions 1 to 71 that are not powers of two. Check bit i (i = 0 to 6) is the XOR of the data bits whose position has bit i set. Check bit 7 is the XOR of all 64 data bits and check bits 0 to 6.
- R5: On the clock edge that accepts a beat, every mask that is not written in that same cycle clears to zero, so the following beat is unmodified.
- R6: A mask write in the same cycle as an accepted beat does not affect that beat. The new value is kept and applies to the next accepted beat.
- R7: While no beat is accepted (valid without ready, or ready without valid), the masks keep their values, `out_valid` is low and `out_word` holds its last value.
- R8: With `DATA_W` = 64, writes to addresses 2 and 3 are ignored.
- R9: With `ECC_EN` or `FI_TEST_EN` at 0, mask writes are ignored and the output data equals the input data.
- R10: An all-zero mask leaves the data unchanged.
- R11: With `DATA_W` = 128, mask words 2 and 3 invert data bits [95:64] and [127:96]. Each lane's check byte is encoded from that lane's own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; released synchronously |
| cfg_wr_en | input | 1 | Mask register write strobe |
| cfg_wr_addr | input | ADDR_W | Mask word select |
| cfg_wr_data | input | 32 | Mask value to load |
| wr_valid | input | 1 | Write beat valid |
| wr_ready | input | 1 | Write beat ready from the downstream stage |
| wr_data | input | DATA_W | Write data |
| out_valid | output | 1 | Registered beat valid |
| out_word | output | DATA_W+8*DATA_W/64 | Data in the low bits, check bytes above |

## Verification
A mask write or a beat acceptance changes the mask state on the same rising edge. A beat's corrupted data and its check bytes appear on `out_word` one edge after acceptance, together with `out_valid`. The bench drives each cycle's inputs at the falling edge and, at that moment, computes the expected output from its own mask model as it stood before the edge. It then updates the model the way the edge should, and compares the outputs at the next falling edge, one edge later. Stalled cycles are compared against the held word, so a beat or mask change that leaks through shows up in the very next sample.

// File: rtl/ecc_fi_pkg.sv
package ecc_fi_pkg;

  localparam int MASK_W   = 32;
  localparam int LANE_W   = 64;
  localparam int LANE_CHK = 8;

  // SECDED check byte for one 64-bit lane: low 7 bits are the XOR of the
  // codeword positions of all set data bits, bit 7 is overall even parity.
  function automatic logic [7:0] secded64(input logic [63:0] d);
    logic [6:0] syn;
    int         j;
    syn = '0;
    j   = 0;
    for (int p = 1; p < 72; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (d[j]) syn = syn ^ 7'(p);
        j++;
      end
    end
    return {(^d) ^ (^syn), syn};
  endfunction

endpackage

// File: rtl/fi_mask_bank.sv
module fi_mask_bank
  import ecc_fi_pkg::*;
#(
  parameter int NUM_MASK = 2,
  parameter int ADDR_W   = 2,
  parameter bit PRESENT  = 1'b1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cfg_wr_en,
  input  logic [ADDR_W-1:0]          cfg_wr_addr,
  input  logic [MASK_W-1:0]          cfg_wr_data,
  input  logic                       beat_acc,
  output logic [NUM_MASK*MASK_W-1:0] mask_flat
);

  generate
    if (PRESENT) begin : g_bank
      logic [NUM_MASK-1:0][MASK_W-1:0] mask_q;
      logic [NUM_MASK-1:0][MASK_W-1:0] mask_d;
      logic                            mask_en;

      assign mask_en = beat_acc | cfg_wr_en;

      always_comb begin
        mask_d = mask_q;
        if (beat_acc) mask_d = '0;
        for (int k = 0; k < NUM_MASK; k++) begin
          if (cfg_wr_en && (cfg_wr_addr == ADDR_W'(k))) mask_d[k] = cfg_wr_data;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       mask_q <= '0;
        else if (mask_en) mask_q <= mask_d;
      end

      assign mask_flat = mask_q;
    end else begin : g_none
      assign mask_flat = '0;
    end
  endgenerate

endmodule

// File: rtl/secded_lane_enc.sv
module secded_lane_enc
  import ecc_fi_pkg::*;
#(
  parameter bit ENABLE = 1'b1
) (
  input  logic [LANE_W-1:0]   lane_data,
  output logic [LANE_CHK-1:0] lane_chk
);

  generate
    if (ENABLE) begin : g_enc
      assign lane_chk = secded64(lane_data);
    end else begin : g_off
      assign lane_chk = '0;
    end
  endgenerate

endmodule

// File: rtl/fi_out_stage.sv
module fi_out_stage #(
  parameter int W = 72
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d_in,
  output logic         valid_q,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= load;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d_in;
  end

endmodule

// File: rtl/ecc_fault_inject.sv
module ecc_fault_inject
  import ecc_fi_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int ADDR_W     = 2,
  parameter bit ECC_EN     = 1'b1,
  parameter bit FI_TEST_EN = 1'b1
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                cfg_wr_en,
  input  logic [ADDR_W-1:0]                   cfg_wr_addr,
  input  logic [MASK_W-1:0]                   cfg_wr_data,
  input  logic                                wr_valid,
  input  logic                                wr_ready,
  input  logic [DATA_W-1:0]                   wr_data,
  output logic                                out_valid,
  output logic [DATA_W+LANE_CHK*(DATA_W/LANE_W)-1:0] out_word
);

  localparam int NUM_MASK = DATA_W / MASK_W;
  localparam int LANES    = DATA_W / LANE_W;
  localparam int CHK_W    = LANE_CHK * LANES;
  localparam bit FI_EN    = ECC_EN && FI_TEST_EN;

  logic                 beat_acc;
  logic [DATA_W-1:0]    mask_flat;
  logic [CHK_W-1:0]     chk_bits;
  logic [DATA_W-1:0]    data_flipped;

  assign beat_acc = wr_valid & wr_ready;

  fi_mask_bank #(
    .NUM_MASK (NUM_MASK),
    .ADDR_W   (ADDR_W),
    .PRESENT  (FI_EN)
  ) u_masks (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_addr (cfg_wr_addr),
    .cfg_wr_data (cfg_wr_data),
    .beat_acc    (beat_acc),
    .mask_flat   (mask_flat)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      secded_lane_enc #(
        .ENABLE (ECC_EN)
      ) u_enc (
        .lane_data (wr_data[l*LANE_W +: LANE_W]),
        .lane_chk  (chk_bits[l*LANE_CHK +: LANE_CHK])
      );
    end
  endgenerate

  // Faults land only on data bits, after the check bits were formed.
  assign data_flipped = wr_data ^ mask_flat;

  fi_out_stage #(
    .W (DATA_W + CHK_W)
  ) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (beat_acc),
    .d_in    ({chk_bits, data_flipped}),
    .valid_q (out_valid),
    .q       (out_word)
  );

endmodule

// File: rtl/ecc_fi_checker.sv
module ecc_fi_checker
  import ecc_fi_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int CHK_W      = 8,
  parameter bit ECC_EN     = 1'b1,
  parameter bit FI_TEST_EN = 1'b1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cfg_wr_en,
  input logic                    wr_valid,
  input logic                    wr_ready,
  input logic [DATA_W-1:0]       wr_data,
  input logic [DATA_W-1:0]       mask_flat,
  input logic                    out_valid,
  input logic [DATA_W+CHK_W-1:0] out_word
);

  logic acc;
  assign acc = wr_valid && wr_ready;

  a_r2_valid_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

  a_r7_no_valid_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> !out_valid);

  a_r7_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(out_word));

  a_r3_data_flip: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (out_word[DATA_W-1:0] == $past(wr_data ^ mask_flat)));

  a_r5_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !cfg_wr_en) |=> (mask_flat == '0));

  generate
    if (ECC_EN) begin : g_chk
      a_r4_lane0_check: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_word[DATA_W +: 8] == secded64($past(wr_data[63:0]))));
    end
    if (!(ECC_EN && FI_TEST_EN)) begin : g_off
      a_r9_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (out_word[DATA_W-1:0] == $past(wr_data)));
    end
  endgenerate

endmodule

bind ecc_fault_inject ecc_fi_checker #(
  .DATA_W     (DATA_W),
  .CHK_W      (CHK_W),
  .ECC_EN     (ECC_EN),
  .FI_TEST_EN (FI_TEST_EN)
) u_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cfg_wr_en (cfg_wr_en),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .wr_data   (wr_data),
  .mask_flat (mask_flat),
  .out_valid (out_valid),
  .out_word  (out_word)
);

// File: tb/tb_ecc_fault_inject.sv
module tb_ecc_fault_inject;

  localparam int PERIOD = 10;

  logic         clk;
  logic         rst_n;
  logic         cfg_wr_en;
  logic [1:0]   cfg_wr_addr;
  logic [31:0]  cfg_wr_data;
  logic         wr_valid;
  logic         wr_ready;
  logic [127:0] wr_data;

  logic         o64_v,  ow_v,  off_v;
  logic [71:0]  o64_w,  off_w;
  logic [143:0] ow_w;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 0;

  logic [31:0]  m64  [2];
  logic [31:0]  mw   [4];
  logic [71:0]  e64, eoff;
  logic [143:0] ew;

  ecc_fault_inject #(.DATA_W(64)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data[63:0]), .out_valid(o64_v), .out_word(o64_w));

  ecc_fault_inject #(.DATA_W(128)) dut_wide (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .out_valid(ow_v), .out_word(ow_w));

  ecc_fault_inject #(.DATA_W(64), .FI_TEST_EN(1'b0)) dut_off (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_addr(cfg_wr_addr),
    .cfg_wr_data(cfg_wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data[63:0]), .out_valid(off_v), .out_word(off_w));

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  // Reference encoder built from the codeword-position description.
  function automatic logic [7:0] ref_enc(input logic [63:0] d);
    logic [71:0] cw;
    logic [7:0]  c;
    int          j;
    cw = '0;
    j  = 0;
    for (int pos = 1; pos < 72; pos++) begin
      if (pos != 1 && pos != 2 && pos != 4 && pos != 8 && pos != 16 &&
          pos != 32 && pos != 64) begin
        cw[pos] = d[j];
        j++;
      end
    end
    c = '0;
    for (int i = 0; i < 7; i++)
      for (int pos = 1; pos < 72; pos++)
        if (((pos >> i) & 1) == 1) c[i] = c[i] ^ cw[pos];
    c[7] = (^d) ^ (^c[6:0]);
    return c;
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [143:0] act, input logic [143:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  // One cycle: drive at the falling edge, model the rising edge, compare one edge later.
  task automatic step(input string tag, input bit we, input logic [1:0] a,
                      input logic [31:0] wd, input bit v, input bit r,
                      input logic [127:0] d);
    bit acc;
    cfg_wr_en   = we;
    cfg_wr_addr = a;
    cfg_wr_data = wd;
    wr_valid    = v;
    wr_ready    = r;
    wr_data     = d;
    acc = v && r;
    if (acc) begin
      e64  = {ref_enc(d[63:0]), d[63:0] ^ {m64[1], m64[0]}};
      ew   = {ref_enc(d[127:64]), ref_enc(d[63:0]),
              d ^ {mw[3], mw[2], mw[1], mw[0]}};
      eoff = {ref_enc(d[63:0]), d[63:0]};
    end
    for (int k = 0; k < 4; k++) begin
      if (we && a == 2'(k)) begin
        if (k < 2) m64[k] = wd;
        mw[k] = wd;
      end else if (acc) begin
        if (k < 2) m64[k] = '0;
        mw[k] = '0;
      end
    end
    @(posedge clk);
    @(negedge clk);
    check(o64_v == acc, tag, "dut out_valid", 144'(o64_v), 144'(acc));
    check(ow_v  == acc, tag, "dut_wide out_valid", 144'(ow_v), 144'(acc));
    check(off_v == acc, tag, "dut_off out_valid", 144'(off_v), 144'(acc));
    check(o64_w == e64, tag, "dut out_word", 144'(o64_w), 144'(e64));
    check(ow_w  == ew,  tag, "dut_wide out_word", ow_w, ew);
    check(off_w == eoff, tag, "dut_off out_word (R9)", 144'(off_w), 144'(eoff));
  endtask

  task automatic beat(input string tag, input logic [127:0] d);
    step(tag, 1'b0, 2'd0, 32'd0, 1'b1, 1'b1, d);
  endtask

  task automatic wmask(input string tag, input logic [1:0] a, input logic [31:0] wd);
    step(tag, 1'b1, a, wd, 1'b0, 1'b0, '0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [127:0] rd;
    void'($urandom(32'h5eed_1234));
    for (int k = 0; k < 2; k++) m64[k] = '0;
    for (int k = 0; k < 4; k++) mw[k] = '0;
    e64 = '0; ew = '0; eoff = '0;
    rst_n = 1'b0;
    cfg_wr_en = 0; cfg_wr_addr = 0; cfg_wr_data = 0;
    wr_valid = 0; wr_ready = 0; wr_data = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(o64_v == 1'b0 && ow_v == 1'b0, "R1", "out_valid in reset",
          144'({o64_v, ow_v}), 144'(0));
    check(o64_w == '0 && ow_w == '0, "R1", "out_word in reset", ow_w, '0);
    rst_n = 1'b1;
    @(negedge clk);

    beat("R1", 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210);
    beat("R10", '1);
    beat("R4", 128'h1);
    beat("R4", 128'h8000_0000_0000_0000_8000_0000_0000_0000);

    wmask("R3", 2'd0, 32'h0000_0001);
    beat("R3", 128'h0);
    beat("R5", 128'h0);

    wmask("R3", 2'd1, 32'h8000_0000);
    wmask("R3", 2'd0, 32'h0000_0005);
    step("R7", 1'b0, 2'd0, 32'd0, 1'b1, 1'b0, 128'hdead);
    step("R7", 1'b0, 2'd0, 32'd0, 1'b0, 1'b1, 128'hbeef);
    beat("R3", 128'hffff_0000_ffff_0000_ffff_0000_ffff_0000);
    beat("R5", 128'hffff_0000_ffff_0000_ffff_0000_ffff_0000);

    wmask("R8", 2'd2, 32'h0000_ffff);
    wmask("R11", 2'd3, 32'hf0f0_f0f0);
    beat("R11", 128'h0);
    beat("R8", 128'h0);

    wmask("R6", 2'd1, 32'h0000_0003);
    step("R6", 1'b1, 2'd0, 32'h0000_000a, 1'b1, 1'b1, 128'h0);
    beat("R6", 128'h0);
    beat("R5", 128'h0);

    wmask("R10", 2'd0, 32'h0);
    beat("R10", 128'h5555_aaaa);

    for (int n = 0; n < 3000; n++) begin
      rd = {$urandom, $urandom, $urandom, $urandom};
      step("R9", ($urandom % 4) == 0, 2'($urandom), ($urandom % 2) ? $urandom : 32'(1 << ($urandom % 32)),
           ($urandom % 4) != 0, ($urandom % 4) != 0, rd);
    end

    finish_run();
  end

endmodule